// File: doc/BRIEF.md
# Speculative Credit Flow-Control Link

This block joins a word-wide sender and receiver over a point-to-point link that is paced by credits. The sender keeps every accepted word in a small retention store and holds a signed count of the receive slots it believes are free. While that count is above a runtime threshold, it sends the next word on credit. When it has no credit left, it may send a word that has never been on the link before. Such a send is speculative, and it lets a word use receive space that has been freed but whose credit has not yet come back.

The receiver places an arriving word in its FIFO when the word carries the expected sequence tag and there is room. It drops the word in all other cases. The first drop after a good run produces a NACK carrying the dropped word's tag. The receiver then moves from state RX_ACCEPT to state RX_DISCARD, and in that state it silently drops any word whose tag is not the expected one. When the expected word arrives and is accepted, the receiver goes back to RX_ACCEPT. If the expected word arrives while the FIFO is still full, the receiver NACKs it again and stays in RX_DISCARD.

Every accepted word is acknowledged with its tag, and the acknowledgement releases the word from the sender's store. On a NACK, the sender rewinds its send pointer to the NACKed tag and replays from there, in the original order and ahead of new words. Credits come back over a registered return path, one for each freed FIFO slot and one for each dropped word.

Top module: `spec_credit_link`

## Requirements
- R1: After reset the credit count equals RX_DEPTH, `out_valid` is 0, `in_ready` is 1 and `link_valid` is 0.
- R2: Every word accepted at the input leaves at `out_data` exactly once, in acceptance order, with its data unchanged.
- R3: A send on credit (`link_valid`=1 with `link_spec`=0) happens only when, in the cycle before, the credit count was greater than RX_DEPTH minus `credit_limit`. When `spec_en` is 0, no speculative send occurs and no NACK is returned.
- R4: Each word placed on the link lowers the credit count by one. Each slot freed at the receiver raises it by one, two cycles after the pop. A send and a return in the same cycle leave the count unchanged. Once the link is drained, the count returns to RX_DEPTH.
- R5: A speculative send (`link_spec`=1) happens only when, in the cycle before, the credit count was at or below RX_DEPTH minus `credit_limit`, and only when `spec_en` was 1 in the cycle before.
- R6: A word that arrives while the receive FIFO is full is dropped and answered with a NACK (`link_nack`=1). The word gives its credit back, so with the receiver stalled the count settles at 0 rather than −1.
- R7: A word is sent speculatively at most once, and only on its first transmission. Any later transmission of the same word waits for credit.
- R8: After a NACK, the dropped word and every word after it are resent in their original order before any newer word.
- R9: With `credit_limit` set to L (1..RX_DEPTH) and the receiver stalled, exactly L words are sent on credit, and the count stops at RX_DEPTH − L.
- R10: `in_ready` is 0 while the retention store holds TX_DEPTH words that have not been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| spec_en | input | 1 | Allows speculative sends |
| credit_limit | input | LW | Runtime maximum of outstanding credits, 1..RX_DEPTH |
| in_valid | input | 1 | Input word present |
| in_data | input | DATA_W | Input word |
| in_ready | output | 1 | Retention store can take a word |
| out_valid | output | 1 | Receive FIFO holds a word |
| out_data | output | DATA_W | Word at the head of the receive FIFO |
| out_ready | input | 1 | Consumer takes the head word |
| link_valid | output | 1 | A word is on the link this cycle |
| link_spec | output | 1 | The word on the link was sent without credit |
| link_tag | output | PW | Sequence tag of the word on the link |
| link_nack | output | 1 | Receiver returns a NACK this cycle |
| credits | output | CW | Signed credit count held by the sender |

## Verification
A credit count that drifts shows up at the `credits` port once the link is idle: the count settles away from RX_DEPTH within a few cycles of the drain, or away from 0 in the stalled-with-drop case. A wrong rewind pointer, or a receiver stuck in RX_DISCARD, appears at `out_data` as a missing, repeated or reordered word, or as a drain that never finishes. A bad speculation flag appears on the link as a second speculative send of the same tag, or as a speculative send while credit was still available.

// File: rtl/scl_pkg.sv
package scl_pkg;
    typedef enum logic {
        RX_ACCEPT  = 1'b0,
        RX_DISCARD = 1'b1
    } rx_state_e;
endpackage

// File: rtl/scl_sender.sv
module scl_sender #(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4,
    parameter int DATA_W   = 8,
    parameter int PW       = 3,
    parameter int LW       = 3,
    parameter int CW       = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spec_en,
    input  logic [LW-1:0]        credit_limit,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    in_data,
    output logic                 in_ready,
    output logic                 lnk_valid,
    output logic                 lnk_spec,
    output logic [PW-1:0]        lnk_tag,
    output logic [DATA_W-1:0]    lnk_data,
    input  logic                 rsp_ack,
    input  logic                 rsp_nack,
    input  logic [PW-1:0]        rsp_tag,
    input  logic [1:0]           rsp_cred,
    output logic signed [CW-1:0] credits
);
    localparam int IW = PW - 1;

    logic [DATA_W-1:0] store [TX_DEPTH];
    logic [TX_DEPTH-1:0] tried;
    logic [PW-1:0] head_p, send_p, tail_p;
    logic [PW-1:0] occ;
    logic have_word, cred_ok, fire_cred, fire_spec, fire, push;
    logic signed [CW-1:0] thr;

    // Each tag maps to one store slot through its low bits.
    assign occ       = tail_p - head_p;
    assign in_ready  = (occ != PW'(TX_DEPTH));
    assign push      = in_valid && in_ready;
    assign have_word = (send_p != tail_p);
    assign thr       = $signed(CW'(RX_DEPTH)) - $signed(CW'(credit_limit));
    assign cred_ok   = (credits > thr);
    assign fire_cred = have_word && cred_ok;
    assign fire_spec = have_word && !cred_ok && spec_en && !tried[send_p[IW-1:0]];
    assign fire      = fire_cred || fire_spec;

    always_ff @(posedge clk) begin
        if (push) begin
            store[tail_p[IW-1:0]] <= in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tried     <= '0;
            head_p    <= '0;
            send_p    <= '0;
            tail_p    <= '0;
            credits   <= $signed(CW'(RX_DEPTH));
            lnk_valid <= 1'b0;
            lnk_spec  <= 1'b0;
            lnk_tag   <= '0;
            lnk_data  <= '0;
        end else begin
            if (push) begin
                tried[tail_p[IW-1:0]] <= 1'b0;
                tail_p <= tail_p + 1'b1;
            end
            if (fire) begin
                tried[send_p[IW-1:0]] <= 1'b1;
            end
            lnk_valid <= fire;
            lnk_spec  <= fire_spec;
            lnk_tag   <= send_p;
            lnk_data  <= store[send_p[IW-1:0]];
            // A NACK rewinds to the dropped word; the replay keeps the original order.
            if (rsp_nack) begin
                send_p <= rsp_tag;
            end else if (fire) begin
                send_p <= send_p + 1'b1;
            end
            if (rsp_ack) begin
                head_p <= head_p + 1'b1;
            end
            credits <= credits - $signed(CW'(fire)) + $signed(CW'(rsp_cred));
        end
    end
endmodule

// File: rtl/scl_receiver.sv
module scl_receiver
    import scl_pkg::*;
#(
    parameter int RX_DEPTH = 4,
    parameter int DATA_W   = 8,
    parameter int PW       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lnk_valid,
    input  logic [PW-1:0]     lnk_tag,
    input  logic [DATA_W-1:0] lnk_data,
    output logic              rsp_ack,
    output logic              rsp_nack,
    output logic [PW-1:0]     rsp_tag,
    output logic [1:0]        rsp_cred,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);
    localparam int RW = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
    localparam int NW = $clog2(RX_DEPTH + 1);

    logic [DATA_W-1:0] fifo [RX_DEPTH];
    logic [RW-1:0] rd_p, wr_p;
    logic [NW-1:0] cnt;
    logic [PW-1:0] exp_tag;
    rx_state_e state, nstate;
    logic full, match, accept, drop, nack, pop;

    assign full      = (cnt == NW'(RX_DEPTH));
    assign out_valid = (cnt != '0);
    assign out_data  = fifo[rd_p];
    assign pop       = out_valid && out_ready;
    assign match     = (lnk_tag == exp_tag);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_ACCEPT;
        end else begin
            state <= nstate;
        end
    end

    always_comb begin
        nstate = state;
        accept = 1'b0;
        drop   = 1'b0;
        nack   = 1'b0;
        unique case (state)
            RX_ACCEPT: begin
                accept = lnk_valid && match && !full;
                drop   = lnk_valid && !accept;
                nack   = drop;
                if (nack) nstate = RX_DISCARD;
            end
            RX_DISCARD: begin
                accept = lnk_valid && match && !full;
                drop   = lnk_valid && !accept;
                nack   = drop && match;
                if (accept) nstate = RX_ACCEPT;
            end
            default: nstate = RX_ACCEPT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            fifo[wr_p] <= lnk_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_p     <= '0;
            wr_p     <= '0;
            cnt      <= '0;
            exp_tag  <= '0;
            rsp_ack  <= 1'b0;
            rsp_nack <= 1'b0;
            rsp_tag  <= '0;
            rsp_cred <= 2'd0;
        end else begin
            if (accept) begin
                wr_p    <= (wr_p == RW'(RX_DEPTH - 1)) ? '0 : wr_p + 1'b1;
                exp_tag <= exp_tag + 1'b1;
            end
            if (pop) begin
                rd_p <= (rd_p == RW'(RX_DEPTH - 1)) ? '0 : rd_p + 1'b1;
            end
            cnt      <= cnt + NW'(accept) - NW'(pop);
            rsp_ack  <= accept;
            rsp_nack <= nack;
            rsp_tag  <= lnk_tag;
            // A freed slot and a dropped word each give one credit back.
            rsp_cred <= {1'b0, pop} + {1'b0, drop};
        end
    end
endmodule

// File: rtl/spec_credit_link.sv
module spec_credit_link #(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4,
    parameter int DATA_W   = 8,
    localparam int PW = $clog2(TX_DEPTH) + 1,
    localparam int LW = $clog2(RX_DEPTH + 1),
    localparam int CW = $clog2(RX_DEPTH + TX_DEPTH + 1) + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spec_en,
    input  logic [LW-1:0]        credit_limit,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    in_data,
    output logic                 in_ready,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_data,
    input  logic                 out_ready,
    output logic                 link_valid,
    output logic                 link_spec,
    output logic [PW-1:0]        link_tag,
    output logic                 link_nack,
    output logic signed [CW-1:0] credits
);
    logic [DATA_W-1:0] lnk_data;
    logic rsp_ack, rsp_nack;
    logic [PW-1:0] rsp_tag;
    logic [1:0] rsp_cred;

    scl_sender #(
        .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .DATA_W(DATA_W),
        .PW(PW), .LW(LW), .CW(CW)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .spec_en(spec_en), .credit_limit(credit_limit),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .lnk_valid(link_valid), .lnk_spec(link_spec), .lnk_tag(link_tag),
        .lnk_data(lnk_data), .rsp_ack(rsp_ack), .rsp_nack(rsp_nack),
        .rsp_tag(rsp_tag), .rsp_cred(rsp_cred), .credits(credits)
    );

    scl_receiver #(
        .RX_DEPTH(RX_DEPTH), .DATA_W(DATA_W), .PW(PW)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .lnk_valid(link_valid), .lnk_tag(link_tag),
        .lnk_data(lnk_data), .rsp_ack(rsp_ack), .rsp_nack(rsp_nack),
        .rsp_tag(rsp_tag), .rsp_cred(rsp_cred), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready)
    );

    assign link_nack = rsp_nack;
endmodule

// File: rtl/scl_checker.sv
module scl_checker #(
    parameter int RX_DEPTH = 4,
    parameter int LW = 3,
    parameter int CW = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 spec_en,
    input logic [LW-1:0]        credit_limit,
    input logic                 link_valid,
    input logic                 link_spec,
    input logic signed [CW-1:0] credits
);
    // R3: a send on credit needs a count above the threshold set by the limit
    a_r3_credited_send: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && !link_spec) |->
            (int'($past(credits)) > (RX_DEPTH - int'($past(credit_limit)))));

    // R5: a speculative send only when there is no credit
    a_r5_spec_without_credit: assert property (@(posedge clk) disable iff (!rst_n)
        link_spec |-> (int'($past(credits)) <= (RX_DEPTH - int'($past(credit_limit)))));

    // R5: a speculative send only while speculation is enabled
    a_r5_spec_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        link_spec |-> $past(spec_en));

    // R4: per cycle the count falls by at most one and rises by at most two
    a_r4_credit_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(credits) - int'($past(credits)) >= -1) &&
         (int'(credits) - int'($past(credits)) <= 2)));

    // R4: the count never rises above the receive depth
    a_r4_credit_cap: assert property (@(posedge clk) disable iff (!rst_n)
        int'(credits) <= RX_DEPTH);

    // R5: the speculation flag is only seen together with a word on the link
    a_r5_spec_has_word: assert property (@(posedge clk) disable iff (!rst_n)
        link_spec |-> link_valid);
endmodule

bind spec_credit_link scl_checker #(.RX_DEPTH(RX_DEPTH), .LW(LW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .spec_en(spec_en), .credit_limit(credit_limit),
    .link_valid(link_valid), .link_spec(link_spec), .credits(credits)
);

// File: tb/spec_credit_link_bench.sv
module spec_credit_link_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TXD = 4;
    localparam int RXD = 4;
    localparam int DW  = 8;
    localparam int PW  = $clog2(TXD) + 1;
    localparam int LW  = $clog2(RXD + 1);
    localparam int CW  = $clog2(RXD + TXD + 1) + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spec_en = 1'b0;
    logic [LW-1:0] credit_limit = LW'(RXD);
    logic in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic in_ready, out_valid, link_valid, link_spec, link_nack;
    logic [DW-1:0] out_data;
    logic out_ready = 1'b0;
    logic [PW-1:0] link_tag;
    logic signed [CW-1:0] credits;

    int compared = 0;
    int mismatched = 0;
    int rdy_mode = 0;
    int cyc = 0;
    int wr_i = 0;
    int rd_i = 0;
    int spec_cnt = 0;
    int nack_cnt = 0;
    int prev_cred = RXD;
    int prev_lim = RXD;
    logic [DW-1:0] exp_q [1024];
    logic [PW-1:0] acc_tag = '0;
    logic [(1<<PW)-1:0] sent_seen = '0;

    spec_credit_link #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .DATA_W(DW)) u_spec_credit_link (
        .clk(clk), .rst_n(rst_n), .spec_en(spec_en), .credit_limit(credit_limit),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .link_valid(link_valid), .link_spec(link_spec), .link_tag(link_tag),
        .link_nack(link_nack), .credits(credits)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Consumer pacing: 0 never, 1 always, 2 every other cycle, 3 one in three, 4 a single pop
    always @(posedge clk) begin
        #1;
        case (rdy_mode)
            1: out_ready = 1'b1;
            2: out_ready = cyc[0];
            3: out_ready = (cyc % 3 == 0);
            4: begin out_ready = 1'b1; rdy_mode = 0; end
            default: out_ready = 1'b0;
        endcase
    end

    // Monitor, sampled away from the rising edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (in_valid && in_ready) begin
                exp_q[wr_i % 1024] = in_data;
                sent_seen[acc_tag] = 1'b0;
                acc_tag = acc_tag + 1'b1;
                wr_i++;
            end
            if (out_valid && out_ready) begin
                // R2 R8: in-order, exactly-once delivery
                chk(out_data == exp_q[rd_i % 1024], "R2 R8 order", int'(out_data),
                    int'(exp_q[rd_i % 1024]));
                rd_i++;
            end
            if (link_valid) begin
                if (link_spec) begin
                    spec_cnt++;
                    chk(!sent_seen[link_tag], "R7 spec only on first send", 1, 0);
                    chk(prev_cred <= RXD - prev_lim, "R5 spec without credit", prev_cred,
                        RXD - prev_lim);
                end
                sent_seen[link_tag] = 1'b1;
            end
            if (link_nack) nack_cnt++;
        end
        prev_cred = int'(credits);
        prev_lim  = int'(credit_limit);
    end

    task automatic push(input logic [DW-1:0] d);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_data  = d;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input string req);
        rdy_mode = 1;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (rd_i == wr_i && !out_valid) break;
        end
        wait_cycles(8);
        chk(rd_i == wr_i, req, rd_i, wr_i);
        chk(int'(credits) == RXD, "R4 credits back after drain", int'(credits), RXD);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        mismatched++;
        compared++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int n0;
        int s0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(int'(credits) == RXD, "R1 credits", int'(credits), RXD);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(link_valid == 1'b0, "R1 link_valid", int'(link_valid), 0);

        // R4: three credited sends against a stalled receiver
        spec_en = 1'b0; rdy_mode = 0;
        for (int i = 0; i < 3; i++) push(DW'(8'h10 + i));
        wait_cycles(10);
        chk(int'(credits) == RXD - 3, "R4 one credit per send", int'(credits), RXD - 3);
        rdy_mode = 4;
        wait_cycles(8);
        chk(int'(credits) == RXD - 2, "R4 one credit per pop", int'(credits), RXD - 2);
        drain("R2 drain basic");

        // R9 and R10: lowered limit, then a full retention store
        credit_limit = LW'(2); rdy_mode = 0;
        for (int i = 0; i < 6; i++) push(DW'(8'h30 + i));
        wait_cycles(10);
        chk(int'(credits) == RXD - 2, "R9 limit throttles sends", int'(credits), RXD - 2);
        chk(in_ready == 1'b0, "R10 store full", int'(in_ready), 0);
        drain("R2 drain after limit");
        credit_limit = LW'(RXD);

        // R6 and R7: a speculative word dropped by a full receiver
        spec_en = 1'b1; rdy_mode = 0;
        n0 = nack_cnt; s0 = spec_cnt;
        for (int i = 0; i < 5; i++) push(DW'(8'h50 + i));
        wait_cycles(15);
        chk(int'(credits) == 0, "R6 drop returns credit", int'(credits), 0);
        chk(nack_cnt - n0 == 1, "R6 one NACK", nack_cnt - n0, 1);
        chk(spec_cnt - s0 == 1, "R7 single speculative try", spec_cnt - s0, 1);
        drain("R8 replay delivers all");

        // Sweep: limit x speculation x consumer pacing
        for (int lim = 1; lim <= RXD; lim++) begin
            for (int sp = 0; sp < 2; sp++) begin
                for (int pat = 0; pat < 4; pat++) begin
                    credit_limit = LW'(lim);
                    spec_en = sp[0];
                    rdy_mode = pat;
                    n0 = nack_cnt;
                    for (int i = 0; i < 12; i++) begin
                        if (pat == 0 && i == 4) rdy_mode = 1;
                        push(DW'(lim * 64 + sp * 32 + pat * 8 + i));
                    end
                    drain("R2 sweep delivery");
                    if (sp == 0) begin
                        chk(nack_cnt == n0, "R3 no NACK without speculation", nack_cnt - n0, 0);
                    end
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule